// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Processor Core

This block is a 32-bit load/store processor core that completes one instruction in every clock cycle. In that one cycle the instruction word is read from a local instruction store, split into its fields, and decoded into a set of control signals. The same cycle also reads two operands from a 32-entry register file, runs the ALU with either the second register or an extended 16-bit immediate, optionally reads or writes a local data store, writes the result back, and picks the next program counter. Both stores are word arrays with combinational reads and clocked writes.

While reset is held, the memories are filled through a simple word-write load port. After reset is released the core runs from address 0. The result of each instruction is visible at the ports before the edge that commits it. These outputs are the register write (enable, index, data), the data-store write (enable, address, data), the current program counter and a signed-overflow status flag.

The core covers register-register arithmetic, logic, comparison and shifts, the immediate forms of add, compare, and and or, word load and store, equal and not-equal branches, absolute jumps with and without link, and register-indirect jumps.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active low. While reset is held, the PC reads 0 and every register is cleared. Load-port writes with `ld_imem_i`=1 fill the instruction store, and with `ld_imem_i`=0 they fill the data store, at word index `ld_addr_i`.
- R2: The opcode sits in bits 31:26. The R-form fields are rs 25:21, rt 20:16, rd 15:11, shamt 10:6 and funct 5:0. Opcode 0 with funct 32/34/36/37 writes rs+rt, rs−rt, rs AND rt and rs OR rt into rd.
- R3: Opcode 0 with funct 0/2/3 shifts rt left logical, right logical or right arithmetic by the 5-bit shamt field, and writes the result to rd.
- R4: The I-form fields are rs 25:21, rt 20:16 and imm 15:0. Opcodes 8/9 (add), 12 (and) and 13 (or) write rs combined with the immediate into rt. The and/or forms zero-extend the immediate; all other immediate users sign-extend it.
- R5: Funct 42 and opcode 10 write 1 when rs is smaller than the second operand in signed order, and 0 otherwise.
- R6: Opcode 43 writes rt to the data word at rs+sext(imm) and makes no register write. Opcode 35 writes the data word at that address into rt.
- R7: Register 0 always reads zero. An instruction aimed at it shows `wb_en_o`=0.
- R8: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When the branch is taken, the next PC is PC+4+(sext(imm)<<2); otherwise it is PC+4. Negative offsets move backwards.
- R9: The J-form has target in bits 25:0. Opcodes 2 and 3 set the next PC to {(PC+4)[31:28], target, 00}. Opcode 3 also writes PC+4 into register 31.
- R10: Opcode 0 with funct 8 sets the next PC to rs and makes no register write.
- R11: `ovf_o` is 1 when funct 32, funct 34 or opcode 8 overflows in signed arithmetic. Opcode 9 never raises it. The result is still written and no trap is taken.
- R12: An unknown opcode or funct makes no register or memory write, and the next PC is PC+4.
- R13: Any instruction that is not a taken branch or jump advances the PC by 4. Exactly one instruction commits per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we_i | input | 1 | Load-port word write strobe |
| ld_imem_i | input | 1 | 1 selects instruction store, 0 data store |
| ld_addr_i | input | LD_AW (6) | Load-port word index |
| ld_data_i | input | 32 | Load-port write data |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write happens at next edge |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | Data-store write happens at next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Stored word |
| ovf_o | output | 1 | Signed overflow status |

## Verification
The bench builds the core with its default sizes of 64 instruction words and 64 data words. That is enough for a program of about forty instructions placed at fixed word indices, and for a jump-and-link target that lies beyond the return point. The program runs sign- and zero-extension pairs and overflow at the 0x7FFFFFFF edge with and without the unsigned form. It also covers store-then-load through the data store, a write aimed at register 0, forward and backward branches both taken and not taken, an unknown opcode, and a call-return through register 31.

// File: rtl/sc_pkg.sv
// sc_pkg: shared encodings and the decoded control bundle for the
// single-cycle core. Assumes a 32-bit word and a 6-bit primary opcode.
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_J     = 6'd2;
    localparam logic [5:0] OP_JAL   = 6'd3;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_ADDIU = 6'd9;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ANDI  = 6'd12;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_SRA = 6'd3;
    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_RD, DST_RT, DST_LINK
    } dst_e;

    typedef struct packed {
        logic    reg_we;
        dst_e    dst;
        logic    use_imm;
        logic    sign_ext;
        logic    mem_we;
        logic    mem_rd;
        logic    br_eq;
        logic    br_ne;
        logic    jmp;
        logic    jreg;
        logic    link;
        logic    ovf_chk;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// sc_decode: turns opcode and funct into the control bundle.
// Assumes unknown encodings must produce no writes and no flow change.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);

    // Main decode table: everything defaults to a no-op.
    always_comb begin
        ctrl_o          = '0;
        ctrl_o.dst      = DST_RT;
        ctrl_o.alu_op   = ALU_ADD;
        ctrl_o.sign_ext = 1'b1;
        unique case (opcode_i)
            OP_RTYPE: begin
                ctrl_o.dst    = DST_RD;
                ctrl_o.reg_we = 1'b1;
                case (funct_i)
                    FN_ADD: begin ctrl_o.alu_op = ALU_ADD; ctrl_o.ovf_chk = 1'b1; end
                    FN_SUB: begin ctrl_o.alu_op = ALU_SUB; ctrl_o.ovf_chk = 1'b1; end
                    FN_AND: ctrl_o.alu_op = ALU_AND;
                    FN_OR:  ctrl_o.alu_op = ALU_OR;
                    FN_SLT: ctrl_o.alu_op = ALU_SLT;
                    FN_SLL: ctrl_o.alu_op = ALU_SLL;
                    FN_SRL: ctrl_o.alu_op = ALU_SRL;
                    FN_SRA: ctrl_o.alu_op = ALU_SRA;
                    FN_JR: begin
                        ctrl_o.reg_we = 1'b0;
                        ctrl_o.jreg   = 1'b1;
                    end
                    default: ctrl_o.reg_we = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.ovf_chk = 1'b1;
            end
            OP_ADDIU: begin
                ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1;
            end
            OP_SLTI: begin
                ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.alu_op = ALU_SLT;
            end
            OP_ANDI: begin
                ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1;
                ctrl_o.sign_ext = 1'b0; ctrl_o.alu_op = ALU_AND;
            end
            OP_ORI: begin
                ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1;
                ctrl_o.sign_ext = 1'b0; ctrl_o.alu_op = ALU_OR;
            end
            OP_LW: begin
                ctrl_o.reg_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.mem_rd = 1'b1;
            end
            OP_SW: begin
                ctrl_o.use_imm = 1'b1; ctrl_o.mem_we = 1'b1;
            end
            OP_BEQ: ctrl_o.br_eq = 1'b1;
            OP_BNE: ctrl_o.br_ne = 1'b1;
            OP_J:   ctrl_o.jmp   = 1'b1;
            OP_JAL: begin
                ctrl_o.jmp = 1'b1; ctrl_o.link = 1'b1;
                ctrl_o.reg_we = 1'b1; ctrl_o.dst = DST_LINK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// sc_alu: combinational ALU. Shifts act on operand b by shamt.
// Assumes the caller decides whether the overflow flag matters.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e              op_i,
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    input  logic [$clog2(W)-1:0] shamt_i,
    output logic [W-1:0]         y_o,
    output logic                 ovf_o
);

    // Operation select and signed-overflow detection.
    always_comb begin
        ovf_o = 1'b0;
        unique case (op_i)
            ALU_ADD: begin
                y_o   = a_i + b_i;
                ovf_o = (a_i[W-1] == b_i[W-1]) && (y_o[W-1] != a_i[W-1]);
            end
            ALU_SUB: begin
                y_o   = a_i - b_i;
                ovf_o = (a_i[W-1] != b_i[W-1]) && (y_o[W-1] != a_i[W-1]);
            end
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            ALU_SLL: y_o = b_i << shamt_i;
            ALU_SRL: y_o = b_i >> shamt_i;
            ALU_SRA: y_o = $unsigned($signed(b_i) >>> shamt_i);
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// sc_regfile: two combinational read ports, one clocked write port.
// Assumes the caller never requests a write to index 0; reset clears all.
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic [AW-1:0] ra_i,
    input  logic [AW-1:0] rb_i,
    output logic [W-1:0]  da_o,
    output logic [W-1:0]  db_o
);

    logic [W-1:0] regs_q [N];

    // Clear on reset, otherwise commit the enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we_i) begin
            regs_q[wa_i] <= wd_i;
        end
    end

    assign da_o = regs_q[ra_i];
    assign db_o = regs_q[rb_i];

    // R7: the zero register must never have been disturbed.
    a_r7_r0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_i == '0) |-> (da_o == '0));

endmodule

// File: rtl/sc_wordmem.sv
// sc_wordmem: word array, combinational read, clocked write.
// Assumes no reset of contents; it is filled before use.
module sc_wordmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);

    logic [W-1:0] mem_q [WORDS];

    // Clocked word write.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sc_core.sv
// sc_core: single-cycle core top. Fetch, decode, execute, memory and
// write-back all settle within one clock; the edge commits them.
// Assumes memories are filled through the load port while reset is held.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW   = $clog2(IMEM_WORDS),
    localparam int DAW   = $clog2(DMEM_WORDS),
    localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we_i,
    input  logic             ld_imem_i,
    input  logic [LD_AW-1:0] ld_addr_i,
    input  logic [31:0]      ld_data_i,
    output logic [31:0]      pc_o,
    output logic             wb_en_o,
    output logic [4:0]       wb_idx_o,
    output logic [31:0]      wb_data_o,
    output logic             st_en_o,
    output logic [31:0]      st_addr_o,
    output logic [31:0]      st_data_o,
    output logic             ovf_o
);

    logic [31:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dmem_rdata;
    logic [5:0]  opcode, funct;
    logic [4:0]  rs, rt, rd, shamt;
    logic [15:0] imm;
    logic [25:0] target;
    logic        alu_ovf, br_taken, dmem_we;
    logic [DAW-1:0] dmem_waddr;
    logic [31:0]    dmem_wdata;
    ctrl_t       ctrl;

    // Instruction store: load port writes, PC reads.
    sc_wordmem #(.W(32), .WORDS(IMEM_WORDS)) u_imem (
        .clk     (clk),
        .we_i    (ld_we_i & ld_imem_i),
        .waddr_i (ld_addr_i[IAW-1:0]),
        .wdata_i (ld_data_i),
        .raddr_i (pc_q[IAW+1:2]),
        .rdata_o (instr)
    );

    assign opcode = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign shamt  = instr[10:6];
    assign funct  = instr[5:0];
    assign imm    = instr[15:0];
    assign target = instr[25:0];

    sc_decode u_dec (
        .opcode_i (opcode),
        .funct_i  (funct),
        .ctrl_o   (ctrl)
    );

    sc_regfile #(.W(32), .N(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wb_en_o),
        .wa_i  (wb_idx_o),
        .wd_i  (wb_data_o),
        .ra_i  (rs),
        .rb_i  (rt),
        .da_o  (rs_val),
        .db_o  (rt_val)
    );

    assign imm_ext = ctrl.sign_ext ? {{16{imm[15]}}, imm} : {16'h0000, imm};
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .op_i    (ctrl.alu_op),
        .a_i     (rs_val),
        .b_i     (alu_b),
        .shamt_i (shamt),
        .y_o     (alu_y),
        .ovf_o   (alu_ovf)
    );

    // Data store: the load port wins over a core store.
    assign dmem_we    = (ld_we_i & ~ld_imem_i) | (rst_n & ctrl.mem_we);
    assign dmem_waddr = ld_we_i ? ld_addr_i[DAW-1:0] : alu_y[DAW+1:2];
    assign dmem_wdata = ld_we_i ? ld_data_i : rt_val;

    sc_wordmem #(.W(32), .WORDS(DMEM_WORDS)) u_dmem (
        .clk     (clk),
        .we_i    (dmem_we),
        .waddr_i (dmem_waddr),
        .wdata_i (dmem_wdata),
        .raddr_i (alu_y[DAW+1:2]),
        .rdata_o (dmem_rdata)
    );

    // Destination pick and write-back source select.
    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   wb_idx_o = rd;
            DST_LINK: wb_idx_o = 5'd31;
            default:  wb_idx_o = rt;
        endcase
        if (ctrl.link)        wb_data_o = pc_plus4;
        else if (ctrl.mem_rd) wb_data_o = dmem_rdata;
        else                  wb_data_o = alu_y;
    end

    assign wb_en_o   = ctrl.reg_we && (wb_idx_o != 5'd0);
    assign st_en_o   = ctrl.mem_we;
    assign st_addr_o = alu_y;
    assign st_data_o = rt_val;
    assign ovf_o     = alu_ovf & ctrl.ovf_chk;

    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], target, 2'b00};
    assign br_taken   = (ctrl.br_eq && (rs_val == rt_val)) ||
                        (ctrl.br_ne && (rs_val != rt_val));

    // Next-PC priority: register jump, absolute jump, branch, sequential.
    always_comb begin
        if (ctrl.jreg)     pc_next = rs_val;
        else if (ctrl.jmp) pc_next = jmp_target;
        else if (br_taken) pc_next = br_target;
        else               pc_next = pc_plus4;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    // R13: non-flow instructions step the PC by one word.
    a_r13_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_taken || ctrl.jmp || ctrl.jreg) |=> (pc_o == $past(pc_o) + 32'd4));

    // R8: a taken branch lands on its computed target.
    a_r8_branch_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !ctrl.jmp && !ctrl.jreg) |=> (pc_o == $past(br_target)));

    // R6: a store never writes a register.
    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        st_en_o |-> !wb_en_o);

    // R11: overflow status only from signed add/sub forms.
    a_r11_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ((opcode == OP_ADDI) ||
                   ((opcode == OP_RTYPE) && ((funct == FN_ADD) || (funct == FN_SUB)))));

endmodule

// File: tb/sc_core_tb_top.sv
// Scoreboard bench: a driver loads a program and queues the expected
// per-cycle commit; a monitor pops and compares at each falling edge.
module sc_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LD_AW      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_we = 1'b0, ld_imem = 1'b0;
    logic [LD_AW-1:0] ld_addr = '0;
    logic [31:0]      ld_data = '0;
    logic [31:0]      pc, wb_data, st_addr, st_data;
    logic [4:0]       wb_idx;
    logic             wb_en, st_en, ovf;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    typedef struct packed {
        logic [31:0] pc;
        logic        wb_en;
        logic [4:0]  idx;
        logic [31:0] data;
        logic        st_en;
        logic [31:0] st_addr;
        logic [31:0] st_data;
        logic        ovf;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we_i   (ld_we),
        .ld_imem_i (ld_imem),
        .ld_addr_i (ld_addr),
        .ld_data_i (ld_data),
        .pc_o      (pc),
        .wb_en_o   (wb_en),
        .wb_idx_o  (wb_idx),
        .wb_data_o (wb_data),
        .st_en_o   (st_en),
        .st_addr_o (st_addr),
        .st_data_o (st_data),
        .ovf_o     (ovf)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(int op, int tgt);
        return {op[5:0], tgt[25:0]};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(string tag, logic [31:0] p, logic we, int idx, logic [31:0] d,
                        logic se, logic [31:0] sa, logic [31:0] sd, logic ov);
        exp_t e;
        e.pc = p; e.wb_en = we; e.idx = idx[4:0]; e.data = d;
        e.st_en = se; e.st_addr = sa; e.st_data = sd; e.ovf = ov;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic exp_wb(string tag, logic [31:0] p, int idx, logic [31:0] d, logic ov);
        push(tag, p, 1'b1, idx, d, 1'b0, '0, '0, ov);
    endtask
    task automatic exp_none(string tag, logic [31:0] p);
        push(tag, p, 1'b0, 0, '0, 1'b0, '0, '0, 1'b0);
    endtask
    task automatic exp_st(string tag, logic [31:0] p, logic [31:0] a, logic [31:0] d);
        push(tag, p, 1'b0, 0, '0, 1'b1, a, d, 1'b0);
    endtask

    task automatic load_word(logic imem, int addr, logic [31:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_imem = imem; ld_addr = addr[LD_AW-1:0]; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare the commit visible before each rising edge.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({t, " R13"}, "pc", pc, e.pc);
            chk(t, "wb_en", {31'd0, wb_en}, {31'd0, e.wb_en});
            if (e.wb_en) begin
                chk(t, "wb_idx", {27'd0, wb_idx}, {27'd0, e.idx});
                chk(t, "wb_data", wb_data, e.data);
            end
            chk(t, "st_en", {31'd0, st_en}, {31'd0, e.st_en});
            if (e.st_en) begin
                chk(t, "st_addr", st_addr, e.st_addr);
                chk(t, "st_data", st_data, e.st_data);
            end
            chk(t, "ovf", {31'd0, ovf}, {31'd0, e.ovf});
        end
    end

    // Driver: load program, check reset state, queue expectations, run.
    initial begin
        logic [31:0] prog [42];
        for (int k = 0; k < 42; k++) prog[k] = 32'h0;
        prog[0]  = enc_i(8, 0, 1, 5);
        prog[1]  = enc_i(8, 0, 2, -3);
        prog[2]  = enc_r(1, 2, 3, 0, 32);
        prog[3]  = enc_r(2, 1, 4, 0, 34);
        prog[4]  = enc_r(1, 2, 5, 0, 36);
        prog[5]  = enc_r(1, 2, 6, 0, 37);
        prog[6]  = enc_r(2, 1, 7, 0, 42);
        prog[7]  = enc_r(1, 2, 8, 0, 42);
        prog[8]  = enc_i(12, 2, 9, 16'hFFFF);
        prog[9]  = enc_i(13, 0, 10, 16'h8000);
        prog[10] = enc_i(10, 2, 11, -1);
        prog[11] = enc_i(10, 1, 12, -1);
        prog[12] = enc_r(0, 1, 13, 4, 0);
        prog[13] = enc_r(0, 2, 14, 28, 2);
        prog[14] = enc_r(0, 2, 15, 1, 3);
        prog[15] = enc_i(43, 1, 4, 3);
        prog[16] = enc_i(35, 1, 16, 3);
        prog[17] = enc_i(8, 1, 0, 7);
        prog[18] = enc_r(0, 0, 17, 0, 32);
        prog[19] = enc_i(13, 0, 18, 16'h7FFF);
        prog[20] = enc_r(0, 18, 18, 16, 0);
        prog[21] = enc_i(13, 18, 18, 16'hFFFF);
        prog[22] = enc_i(8, 18, 19, 1);
        prog[23] = enc_i(9, 18, 20, 1);
        prog[24] = enc_r(18, 18, 21, 0, 32);
        prog[25] = enc_r(0, 18, 22, 0, 34);
        prog[26] = enc_i(4, 1, 1, 1);
        prog[27] = enc_i(8, 0, 23, 99);
        prog[28] = enc_i(5, 1, 1, 1);
        prog[29] = enc_i(8, 0, 23, 1);
        prog[30] = enc_i(5, 1, 2, 1);
        prog[31] = enc_i(8, 0, 23, 99);
        prog[32] = enc_i(4, 1, 2, 1);
        prog[33] = enc_i(63, 1, 5, 7);
        prog[34] = enc_j(3, 40);
        prog[35] = enc_i(8, 0, 24, 7);
        prog[36] = enc_j(2, 37);
        prog[37] = enc_i(4, 0, 0, -1);
        prog[40] = enc_i(43, 0, 31, 0);
        prog[41] = enc_r(31, 0, 0, 0, 8);

        repeat (2) @(posedge clk);
        for (int k = 0; k < 42; k++) load_word(1'b1, k, prog[k]);

        @(negedge clk);
        chk("R1", "pc in reset", pc, 32'h0);

        exp_wb("R4 addi", 0, 1, 32'd5, 0);
        exp_wb("R4 addi sext", 4, 2, 32'hFFFFFFFD, 0);
        exp_wb("R2 add", 8, 3, 32'd2, 0);
        exp_wb("R2 sub", 12, 4, 32'hFFFFFFF8, 0);
        exp_wb("R2 and", 16, 5, 32'd5, 0);
        exp_wb("R2 or", 20, 6, 32'hFFFFFFFD, 0);
        exp_wb("R5 slt true", 24, 7, 32'd1, 0);
        exp_wb("R5 slt false", 28, 8, 32'd0, 0);
        exp_wb("R4 andi zext", 32, 9, 32'h0000FFFD, 0);
        exp_wb("R4 ori zext", 36, 10, 32'h00008000, 0);
        exp_wb("R5 slti true", 40, 11, 32'd1, 0);
        exp_wb("R5 slti sext", 44, 12, 32'd0, 0);
        exp_wb("R3 sll", 48, 13, 32'h50, 0);
        exp_wb("R3 srl", 52, 14, 32'hF, 0);
        exp_wb("R3 sra", 56, 15, 32'hFFFFFFFE, 0);
        exp_st("R6 sw", 60, 32'd8, 32'hFFFFFFF8);
        exp_wb("R6 lw", 64, 16, 32'hFFFFFFF8, 0);
        exp_none("R7 write r0", 68);
        exp_wb("R7 read r0", 72, 17, 32'd0, 0);
        exp_wb("R4 ori", 76, 18, 32'h7FFF, 0);
        exp_wb("R3 sll16", 80, 18, 32'h7FFF0000, 0);
        exp_wb("R4 ori max", 84, 18, 32'h7FFFFFFF, 0);
        exp_wb("R11 addi ovf", 88, 19, 32'h80000000, 1);
        exp_wb("R11 addiu no ovf", 92, 20, 32'h80000000, 0);
        exp_wb("R11 add ovf", 96, 21, 32'hFFFFFFFE, 1);
        exp_wb("R11 sub no ovf", 100, 22, 32'h80000001, 0);
        exp_none("R8 beq taken", 104);
        exp_none("R8 bne not taken", 112);
        exp_wb("R8 fallthrough", 116, 23, 32'd1, 0);
        exp_none("R8 bne taken", 120);
        exp_none("R8 beq not taken", 128);
        exp_none("R12 unknown op", 132);
        exp_wb("R9 jal link", 136, 31, 32'd140, 0);
        exp_st("R9 link stored", 160, 32'd0, 32'd140);
        exp_none("R10 jr", 164);
        exp_wb("R10 return", 140, 24, 32'd7, 0);
        exp_none("R9 j", 144);
        for (int k = 0; k < 3; k++) exp_none("R8 backward", 148);

        @(posedge clk);
        #1 rst_n = 1'b1;
        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        summary();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0 pending", exp_q.size());
        summary();
    end

endmodule